// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned N-bit operands and a carry-in, producing an N-bit sum and a carry-out. It has three stages. The first forms a generate and a propagate bit for every position, and folds the carry-in into position 0. The second is a prefix tree that merges these pairs into group generates, and each group generate is a carry. The third forms each sum bit as the exclusive-or of the propagate bit and the incoming carry.

The combining cell is associative but not commutative. Its upper input must always take the more-significant span. A parameter selects the tree shape:
- The dense tree reaches every prefix in log2(N) levels and places a cell at nearly every position on every level.
- The sparse tree first builds power-of-two spans upward, then fills in the remaining carries on a downward pass. It has roughly twice the depth but uses far fewer cells.

An optional output register, with a synchronous active-low reset, breaks the timing path at the block's edge.

Top module: `pfx_adder`

## Requirements
- R1: With `TOPO = TOPO_DENSE` (value 0), `{cout, sum}` equals the (N+1)-bit value `a + b + cin` for every input.
- R2: With `TOPO = TOPO_SPARSE` (value 1), `{cout, sum}` equals the (N+1)-bit value `a + b + cin` for every input.
- R3: The carry-in enters at bit 0: with `a = 0` and `b = 0`, `sum` equals `cin` and `cout` is 0.
- R4: When every bit propagates (`a ^ b` all ones), `cout` equals `cin`, and every bit of `sum` equals the inverse of `cin`.
- R5: When every bit generates (`a & b` all ones), `cout` is 1, `sum[N-1:1]` is all ones, and `sum[0]` equals `cin`.
- R6: Swapping `a` and `b` leaves `sum` and `cout` unchanged.
- R7: With `OUT_REG = 1`, the result for inputs present at a rising clock edge appears on `sum`/`cout` just after that edge and holds until the next edge. With `OUT_REG = 0`, the outputs follow the inputs combinationally.
- R8: With `OUT_REG = 1`, a rising edge with `rst_n` low sets `sum` to 0 and `cout` to 0, whatever the operands are.
- R9: Both topologies give bit-identical `sum` and `cout` for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of a + b + cin |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The bench targets these corner cases:
- **Full-width carry chains.** All-propagate operands with a carry-in set exercise a carry that travels the whole width. A cell that dropped or misordered a span would leave a stray 1 somewhere in the sum.
- **Carry-in fold.** Zero operands with a carry-in show whether the carry-in is folded at bit 0. A design that lost it would return 0.
- **Generate patterns and chains.** All-generate operands, and chains that end at each bit position in turn, hit the positions that the sparse tree fills in only on its downward pass. A missing down-sweep cell would leave those carries at the span-only value.
- **Operand order.** Swapped operands expose a cell with its upper and lower inputs crossed, which would show as an order-dependent sum.
- **Shared stimulus.** Both topologies see the same stimulus and are compared with each other as well as with the arithmetic result.

// File: rtl/pfx_pkg.sv
// Shared types and the combining operator for the prefix adder.
// Assumes callers always pass the more-significant span as 'hi'.
package pfx_pkg;

    // Tree shape selector.
    typedef enum logic [0:0] {
        TOPO_DENSE  = 1'b0,
        TOPO_SPARSE = 1'b1
    } topo_e;

    // Group generate / propagate pair.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a more-significant span (hi) with the adjacent lower span (lo).
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/pfx_bitgen.sv
// Per-bit generate/propagate formation.
// The carry-in is folded into position 0, so the tree's group generate
// at bit i is the carry into bit i+1. The raw propagate goes to the sum stage.
module pfx_bitgen #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] prop,
    output logic [W-1:0] tree_g,
    output logic [W-1:0] tree_p
);

    logic [W-1:0] gen;

    // Raw per-bit generate and propagate.
    always_comb begin
        gen  = a & b;
        prop = a ^ b;
    end

    // Fold the carry-in into position 0; the other bits pass unchanged.
    always_comb begin
        tree_g    = gen;
        tree_p    = prop;
        tree_g[0] = gen[0] | (prop[0] & cin);
        tree_p[0] = 1'b0;
    end

endmodule

// File: rtl/pfx_tree_dense.sv
// Minimum-depth prefix tree: log2(W) levels. On level l, every position
// i >= 2^l merges with position i - 2^l. Assumes W >= 2.
module pfx_tree_dense #(
    parameter int W = 16
) (
    input  logic [W-1:0] g_in,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] grp_g
);
    import pfx_pkg::*;

    localparam int LV = $clog2(W);

    gp_t st [0:LV][W];

    // Level 0 loads the bit pairs.
    for (genvar i = 0; i < W; i++) begin : g_load
        assign st[0][i] = '{g: g_in[i], p: p_in[i]};
    end

    // Each level doubles the span covered at each position.
    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int D = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_pos
            if (i >= D) begin : g_cell
                assign st[l+1][i] = gp_merge(st[l][i], st[l][i-D]);
            end else begin : g_pass
                assign st[l+1][i] = st[l][i];
            end
        end
    end

    // The last level holds the full prefix at each position.
    for (genvar i = 0; i < W; i++) begin : g_out
        assign grp_g[i] = st[LV][i].g;
    end

endmodule

// File: rtl/pfx_tree_sparse.sv
// Sparse prefix tree. The up-sweep builds aligned power-of-two spans at
// positions i with (i+1) a multiple of 2^(l+1). The down-sweep then
// completes the positions left partial, from large strides to small ones.
// Uses 2*log2(W)-1 stages. Assumes W >= 2.
module pfx_tree_sparse #(
    parameter int W = 16
) (
    input  logic [W-1:0] g_in,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] grp_g
);
    import pfx_pkg::*;

    localparam int LV = $clog2(W);
    localparam int NS = 2 * LV - 1;

    gp_t st [0:NS][W];

    // Stage 0 loads the bit pairs.
    for (genvar i = 0; i < W; i++) begin : g_load
        assign st[0][i] = '{g: g_in[i], p: p_in[i]};
    end

    // Up-sweep: merge aligned blocks of width 2*D.
    for (genvar u = 0; u < LV; u++) begin : g_up
        localparam int D = 1 << u;
        for (genvar i = 0; i < W; i++) begin : g_pos
            if (((i + 1) % (2 * D)) == 0) begin : g_cell
                assign st[u+1][i] = gp_merge(st[u][i], st[u][i-D]);
            end else begin : g_pass
                assign st[u+1][i] = st[u][i];
            end
        end
    end

    // Down-sweep: extend each half-block midpoint with the full prefix below it.
    for (genvar j = 0; j < LV - 1; j++) begin : g_dn
        localparam int D = 1 << (LV - 2 - j);
        localparam int S = LV + j;
        for (genvar i = 0; i < W; i++) begin : g_pos
            if ((((i + 1) % (2 * D)) == D) && (i >= 2 * D)) begin : g_cell
                assign st[S+1][i] = gp_merge(st[S][i], st[S][i-D]);
            end else begin : g_pass
                assign st[S+1][i] = st[S][i];
            end
        end
    end

    // The final stage holds the full prefix at each position.
    for (genvar i = 0; i < W; i++) begin : g_out
        assign grp_g[i] = st[NS][i].g;
    end

endmodule

// File: rtl/pfx_sumstage.sv
// Sum formation and the optional output register.
// Assumes grp_g[i] is the carry into bit i+1, with the carry-in already folded.
module pfx_sumstage #(
    parameter int W       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cin,
    input  logic [W-1:0] prop,
    input  logic [W-1:0] grp_g,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] carry;
    logic [W-1:0] sum_c;

    // Carry into each bit: cin at bit 0, the lower prefix elsewhere.
    always_comb begin
        carry = {grp_g[W-2:0], cin};
        sum_c = prop ^ carry;
    end

    if (OUT_REG) begin : g_reg
        // Register the result; the synchronous reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= grp_g[W-1];
            end
        end
    end else begin : g_comb
        // Drive the result straight through.
        always_comb begin
            sum  = sum_c;
            cout = grp_g[W-1];
        end
    end

endmodule

// File: rtl/pfx_adder.sv
// Parallel prefix adder top. TOPO picks the tree shape, and OUT_REG adds
// an output register. Operands are unsigned, and W must be at least 2.
module pfx_adder #(
    parameter int            W       = 16,
    parameter pfx_pkg::topo_e TOPO   = pfx_pkg::TOPO_DENSE,
    parameter bit            OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] prop;
    logic [W-1:0] tree_g;
    logic [W-1:0] tree_p;
    logic [W-1:0] grp_g;

    pfx_bitgen #(.W(W)) u_bitgen (
        .a      (a),
        .b      (b),
        .cin    (cin),
        .prop   (prop),
        .tree_g (tree_g),
        .tree_p (tree_p)
    );

    if (TOPO == pfx_pkg::TOPO_SPARSE) begin : g_sparse
        pfx_tree_sparse #(.W(W)) u_tree (
            .g_in  (tree_g),
            .p_in  (tree_p),
            .grp_g (grp_g)
        );
    end else begin : g_dense
        pfx_tree_dense #(.W(W)) u_tree (
            .g_in  (tree_g),
            .p_in  (tree_p),
            .grp_g (grp_g)
        );
    end

    pfx_sumstage #(.W(W), .OUT_REG(OUT_REG)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .cin   (cin),
        .prop  (prop),
        .grp_g (grp_g),
        .sum   (sum),
        .cout  (cout)
    );

endmodule

// File: rtl/pfx_adder_chk.sv
// Assertion checker bound to pfx_adder. It predicts results from the
// port values only.
module pfx_adder_chk #(
    parameter int W       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout
);

    if (OUT_REG) begin : g_reg
        logic [W:0] exp_q;
        logic       run_q;

        // Hold last edge's arithmetic expectation and whether it was out of reset.
        always_ff @(posedge clk) begin
            exp_q <= {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            run_q <= rst_n;
        end

        // R1/R2: registered result matches the previous edge's operands.
        assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> ({cout, sum} == exp_q));

        // R8: the first edge out of reset still shows the cleared outputs.
        assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !run_q |-> (sum == '0 && cout == 1'b0));

        // R3: zero operands yield the carry-in alone.
        assert_cin_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && $past(a) == '0 && $past(b) == '0)
            |-> (sum == {{(W-1){1'b0}}, $past(cin)} && !cout));

        // R4: an all-propagate word passes the carry-in across the whole width.
        assert_all_prop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && ($past(a) ^ $past(b)) == {W{1'b1}})
            |-> (cout == $past(cin) && sum == {W{!$past(cin)}}));

        // R5: an all-generate word sets the carry-out.
        assert_all_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && ($past(a) & $past(b)) == {W{1'b1}})
            |-> (cout && sum[W-1:1] == {(W-1){1'b1}} && sum[0] == $past(cin)));
    end else begin : g_comb
        // R1/R2: the combinational result matches the operands at each edge.
        always @(posedge clk) begin
            if (rst_n) begin
                assert_comb_result_R1: assert ({cout, sum} ==
                    ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
            end
        end
    end

endmodule

bind pfx_adder pfx_adder_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout)
);

// File: tb/pfx_adder_test.sv
// Scoreboard bench: the driver queues expected items, and the monitor
// compares both topologies one cycle later.
module pfx_adder_test;
    import pfx_pkg::*;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum_d, sum_s;
    logic         cout_d, cout_s;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb [$];

    always #10 clk = ~clk;

    pfx_adder #(.W(W), .TOPO(TOPO_DENSE), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum_d), .cout(cout_d)
    );

    pfx_adder #(.W(W), .TOPO(TOPO_SPARSE), .OUT_REG(1'b1)) uut_sparse (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum_s), .cout(cout_s)
    );

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply operands at a falling edge and queue the expectation.
    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic cv, input string tag);
        item_t it;
        @(negedge clk);
        a = av; b = bv; cin = cv;
        it.a = av; it.b = bv; it.cin = cv; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: just after each rising edge, score the oldest pending item (R7 latency).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [W:0] exp;
                it  = sb.pop_front();
                exp = {1'b0, it.a} + {1'b0, it.b} + {{W{1'b0}}, it.cin};
                check({it.tag, " R1 R7 dense"}, {cout_d, sum_d}, exp);
                check({it.tag, " R2 sparse"},   {cout_s, sum_s}, exp);
                check({it.tag, " R9 topologies"}, {cout_s, sum_s}, {cout_d, sum_d});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus.
    initial begin
        // R8: reset clears the outputs even with live operands.
        a = {W{1'b1}}; b = 16'h0001; cin = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset dense",  {cout_d, sum_d}, '0);
        check("R8 reset sparse", {cout_s, sum_s}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: the carry-in alone.
        drive('0, '0, 1'b1, "R3 cin only");
        drive('0, '0, 1'b0, "R3 zero");

        // R4: all-propagate, with and without a carry-in.
        drive(16'hAAAA, 16'h5555, 1'b1, "R4 prop cin1");
        drive(16'hAAAA, 16'h5555, 1'b0, "R4 prop cin0");
        drive({W{1'b1}}, '0, 1'b1, "R4 ones+cin");
        drive(16'h0F0F, 16'hF0F0, 1'b1, "R4 prop mix");

        // R5: all-generate.
        drive({W{1'b1}}, {W{1'b1}}, 1'b0, "R5 gen cin0");
        drive({W{1'b1}}, {W{1'b1}}, 1'b1, "R5 gen cin1");

        // R1: a carry chain that stops at each bit in turn.
        for (int k = 0; k < W; k++) begin
            drive(W'((1 << k) - 1), 16'h0001, 1'b0, "R1 chain");
            drive(W'((1 << k) - 1), '0, 1'b1, "R1 chain cin");
        end

        // R6: swapped operands, each queued with its own expectation.
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] x, y;
            logic c;
            x = W'($urandom);
            y = W'($urandom);
            c = 1'($urandom);
            drive(x, y, c, "R6 order ab");
            drive(y, x, c, "R6 order ba");
        end

        // R1/R2: random operands.
        for (int k = 0; k < 400; k++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        end

        repeat (4) @(posedge clk);
        #2;
        finish_run();
    end

endmodule